// File: doc/BRIEF.md
# Predicated Ordered Load Operator

This block is one memory-load node of a dataflow circuit. It joins three elastic inputs: an address, a predicate bit and an ordering token that carries no data. It then reads one word from a synchronous memory port only when the predicate is true. It returns the word on an elastic data output and signals completion on a separate elastic token output. Operations downstream that have side effects wait on that token, so the order of memory effects is set by token wiring and not by a program counter.

A false predicate never touches memory. The node still passes the token on, so the chain of side effects is not broken, and it emits a data value of zero. This is how a load guarded by a condition such as "not overwritten by an earlier store" is kept from reading memory when the guard fails. Only one load is in flight at a time. The node accepts nothing new until both outputs have been taken.

Top module: `pred_load_op`

## Requirements
- R1: While rst_ni is low and the input valids are low, every ready and valid output of the block and mem_req_o are 0.
- R2: The block fires only when address, predicate and token are all valid and it is idle. addr_ready_o, pred_ready_o and tok_ready_o are high together in exactly that cycle, so all three inputs are consumed in the same cycle.
- R3: mem_req_o is high only in a firing cycle whose predicate is 1. A firing with predicate 0 produces no memory request.
- R4: With predicate 0, data_valid_o and tok_valid_o rise after the firing clock edge, and data_o is 0.
- R5: With predicate 1, mem_addr_o equals addr_i in the firing cycle. The memory returns its word one edge later. Both outputs become valid after the following edge, and data_o carries that word.
- R6: An output whose valid is high and whose ready is low keeps its valid high and its data unchanged on the next cycle.
- R7: The data and token outputs complete independently, each on its own valid-and-ready handshake. No input ready and no memory request is given until both outputs have been accepted. Firing is again possible in the cycle after the last acceptance.
- R8: At most one memory read is outstanding. No request is made in the cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Load address |
| addr_valid_i | input | 1 | Address valid |
| addr_ready_o | output | 1 | Address consumed |
| pred_i | input | 1 | Predicate; 1 enables the read |
| pred_valid_i | input | 1 | Predicate valid |
| pred_ready_o | output | 1 | Predicate consumed |
| tok_valid_i | input | 1 | Incoming ordering token |
| tok_ready_o | output | 1 | Incoming token consumed |
| mem_req_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Read data, one edge after the strobe |
| data_o | output | DW | Loaded word, or 0 for a false predicate |
| data_valid_o | output | 1 | Data output valid |
| data_ready_i | input | 1 | Data output taken |
| tok_valid_o | output | 1 | Outgoing completion token |
| tok_ready_i | input | 1 | Outgoing token taken |

## Verification
A stuck wait state would show at once as a second memory strobe, or as outputs that never rise two edges after a true firing. A lost pending flag would drop a valid in the middle of a stall, or would let the inputs be consumed while one output is still held. A wrong predicate path shows in the firing cycle itself, as a strobe on a false predicate or as a missing zero on data_o one edge later. The sweep covers every address, both predicates, each order in which the inputs arrive and every pairing of output stall lengths up to two cycles, so each of these faults shows within a few cycles of the transaction that causes it.

// File: rtl/pred_load_pkg.sv
package pred_load_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ld_state_e;

  localparam int unsigned NUM_IN = 3;
  localparam int unsigned IN_ADDR = 0;
  localparam int unsigned IN_PRED = 1;
  localparam int unsigned IN_TOK = 2;
endpackage

// File: rtl/pred_load_join.sv
module pred_load_join #(
  parameter int unsigned N = 3
) (
  input  logic         en_i,
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] ready_o,
  output logic         fire_o
);
  assign fire_o = en_i & (&valid_i);

  // every operand is consumed in the firing cycle only
  for (genvar g = 0; g < N; g++) begin : g_rdy
    assign ready_o[g] = fire_o;
  end
endmodule

// File: rtl/pred_load_ctrl.sv
module pred_load_ctrl
  import pred_load_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          pred_i,
  input  logic [AW-1:0] addr_i,
  input  logic          fork_busy_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          can_fire_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          load_o,
  output logic [DW-1:0] load_data_o
);
  ld_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    mem_req_o   = 1'b0;
    load_o      = 1'b0;
    load_data_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (fire_i) begin
          if (pred_i) begin
            mem_req_o = 1'b1;
            state_d   = ST_WAIT;
          end else begin
            load_o = 1'b1;  // suppressed load: token only, data zero
          end
        end
      end
      ST_WAIT: begin
        load_o      = 1'b1;
        load_data_o = mem_rdata_i;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign can_fire_o = (state_q == ST_IDLE) && !fork_busy_i;
  assign mem_addr_o = addr_i;

  a_r3_req_needs_pred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> pred_i && fire_i);

  a_r8_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r5_return_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> load_o);

  a_r2_fire_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> !fork_busy_i);
endmodule

// File: rtl/pred_load_fork.sv
module pred_load_fork #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_valid_o,
  input  logic          data_ready_i,
  output logic          tok_valid_o,
  input  logic          tok_ready_i,
  output logic          busy_o
);
  logic          d_pend_q, t_pend_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_pend_q <= 1'b0;
      t_pend_q <= 1'b0;
      data_q   <= '0;
    end else if (load_i) begin
      d_pend_q <= 1'b1;
      t_pend_q <= 1'b1;
      data_q   <= data_i;
    end else begin
      if (d_pend_q && data_ready_i) d_pend_q <= 1'b0;
      if (t_pend_q && tok_ready_i)  t_pend_q <= 1'b0;
    end
  end

  assign data_o       = data_q;
  assign data_valid_o = d_pend_q;
  assign tok_valid_o  = t_pend_q;
  assign busy_o       = d_pend_q | t_pend_q;

  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o && !data_ready_i |=> data_valid_o && $stable(data_o));

  a_r6_tok_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_o && !tok_ready_i |=> tok_valid_o);

  a_r7_no_load_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
endmodule

// File: rtl/pred_load_op.sv
module pred_load_op
  import pred_load_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          addr_valid_i,
  output logic          addr_ready_o,
  input  logic          pred_i,
  input  logic          pred_valid_i,
  output logic          pred_ready_o,
  input  logic          tok_valid_i,
  output logic          tok_ready_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] data_o,
  output logic          data_valid_o,
  input  logic          data_ready_i,
  output logic          tok_valid_o,
  input  logic          tok_ready_i
);
  logic [NUM_IN-1:0] in_valid, in_ready;
  logic              fire, can_fire, fork_busy, load;
  logic [DW-1:0]     load_data;

  assign in_valid[IN_ADDR] = addr_valid_i;
  assign in_valid[IN_PRED] = pred_valid_i;
  assign in_valid[IN_TOK]  = tok_valid_i;
  assign addr_ready_o = in_ready[IN_ADDR];
  assign pred_ready_o = in_ready[IN_PRED];
  assign tok_ready_o  = in_ready[IN_TOK];

  pred_load_join #(.N(NUM_IN)) i_join (
    .en_i    (can_fire),
    .valid_i (in_valid),
    .ready_o (in_ready),
    .fire_o  (fire)
  );

  pred_load_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .pred_i      (pred_i),
    .addr_i      (addr_i),
    .fork_busy_i (fork_busy),
    .mem_rdata_i (mem_rdata_i),
    .can_fire_o  (can_fire),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .load_o      (load),
    .load_data_o (load_data)
  );

  pred_load_fork #(.DW(DW)) i_fork (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .data_i       (load_data),
    .data_o       (data_o),
    .data_valid_o (data_valid_o),
    .data_ready_i (data_ready_i),
    .tok_valid_o  (tok_valid_o),
    .tok_ready_i  (tok_ready_i),
    .busy_o       (fork_busy)
  );

  a_r2_join_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ready_o |-> addr_valid_i && pred_valid_i && tok_valid_i
                     && pred_ready_o && tok_ready_o);

  a_r7_busy_blocks_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o || tok_valid_o) |-> !addr_ready_o && !mem_req_o);

  a_r4_false_pred_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !pred_i |=> data_valid_o && tok_valid_o && (data_o == '0));
endmodule

// File: tb/test_pred_load_op.sv
module test_pred_load_op;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          addr_valid_i = 1'b0, pred_i = 1'b0, pred_valid_i = 1'b0, tok_valid_i = 1'b0;
  logic          addr_ready_o, pred_ready_o, tok_ready_o, mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] data_o;
  logic          data_valid_o, tok_valid_o;
  logic          data_ready_i = 1'b0, tok_ready_i = 1'b0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pred_load_op #(.AW(AW), .DW(DW)) i_pred_load_op (
    .clk_i(clk), .rst_ni(rst_ni),
    .addr_i(addr_i), .addr_valid_i(addr_valid_i), .addr_ready_o(addr_ready_o),
    .pred_i(pred_i), .pred_valid_i(pred_valid_i), .pred_ready_o(pred_ready_o),
    .tok_valid_i(tok_valid_i), .tok_ready_o(tok_ready_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
    .data_o(data_o), .data_valid_o(data_valid_o), .data_ready_i(data_ready_i),
    .tok_valid_o(tok_valid_o), .tok_ready_i(tok_ready_i)
  );

  function automatic logic [DW-1:0] mem_word(input int a);
    return DW'((a * 7 + 3) & 255);
  endfunction

  always_ff @(posedge clk) if (mem_req_o) mem_rdata <= mem_word(int'(mem_addr_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic set_in(input bit v);
    addr_valid_i = v; pred_valid_i = v; tok_valid_i = v;
  endtask

  task automatic run_one(input int a, input bit p, input int last, input int dd, input int td);
    int exp, cyc;
    bit dp, tp, dr, tr, fin;
    exp = p ? int'(mem_word(a)) : 0;
    // partial arrival: one operand missing
    addr_i = AW'(a); pred_i = p;
    addr_valid_i = (last != 0); pred_valid_i = (last != 1); tok_valid_i = (last != 2);
    #1;
    check(!addr_ready_o && !pred_ready_o && !tok_ready_o, "R2 partial", int'(addr_ready_o), 0);
    check(!mem_req_o, "R3 partial no req", int'(mem_req_o), 0);
    @(negedge clk);
    set_in(1'b1);
    #1;
    check(addr_ready_o && pred_ready_o && tok_ready_o, "R2 fire", int'(addr_ready_o), 1);
    check(mem_req_o == p, "R3 req follows pred", int'(mem_req_o), int'(p));
    if (p) check(mem_addr_o == AW'(a), "R5 addr", int'(mem_addr_o), a);
    @(negedge clk);
    set_in(1'b0);
    addr_i = AW'(a + 5);
    #1;
    if (!p) begin
      check(data_valid_o && tok_valid_o, "R4 outs valid", int'(data_valid_o), 1);
      check(data_o == '0, "R4 zero data", int'(data_o), 0);
    end else begin
      check(!data_valid_o && !tok_valid_o, "R5 not yet", int'(data_valid_o), 0);
      check(!mem_req_o, "R8 no second req", int'(mem_req_o), 0);
      @(negedge clk);
      #1;
      check(data_valid_o && tok_valid_o, "R5 outs valid", int'(tok_valid_o), 1);
      check(int'(data_o) == exp, "R5 data", int'(data_o), exp);
    end
    dp = 1'b1; tp = 1'b1; cyc = 0;
    while (dp || tp) begin
      dr = dp && (cyc >= dd);
      tr = tp && (cyc >= td);
      fin = (!dp || dr) && (!tp || tr);
      data_ready_i = dr; tok_ready_i = tr;
      addr_i = AW'(a + 3); pred_i = 1'b1; set_in(!fin);
      #1;
      check(data_valid_o == dp, "R6 data valid held", int'(data_valid_o), int'(dp));
      check(tok_valid_o == tp, "R7 token valid", int'(tok_valid_o), int'(tp));
      if (dp) check(int'(data_o) == exp, "R6 data stable", int'(data_o), exp);
      if (!fin) check(!addr_ready_o && !mem_req_o, "R7 blocked while busy", int'(addr_ready_o), 0);
      @(negedge clk);
      dp = dp && !dr; tp = tp && !tr; cyc++;
    end
    data_ready_i = 1'b0; tok_ready_i = 1'b0; set_in(1'b0); pred_i = p;
    #1;
    check(!data_valid_o && !tok_valid_o, "R7 both accepted", int'(data_valid_o), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!addr_ready_o && !pred_ready_o && !tok_ready_o, "R1 readies", int'(addr_ready_o), 0);
    check(!data_valid_o && !tok_valid_o && !mem_req_o, "R1 outputs", int'(data_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 16; a++)
      for (int p = 0; p < 2; p++)
        for (int last = 0; last < 3; last++)
          for (int dd = 0; dd < 3; dd++)
            for (int td = 0; td < 3; td++)
              run_one(a, p[0], last, dd, td);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule